// File: doc/BRIEF.md
# Virtual-Channel Transmit Frame Engine

This block assembles outgoing raw Ethernet frames for a MAC on behalf of a receive-side parser. The parser hands it one of two kinds of job. A read job names one of several virtual-channel byte streams and carries a serial number. An acknowledge job carries a serial number, a channel and a size to echo back. For a read, the engine steers its channel multiplexer to the named stream. A fetch stage then drains bytes into a local buffer and counts them. When the count is known, the engine asks the MAC for the line, waits for its grant and streams the frame out one byte per cycle. The frame is a Null reply when nothing was fetched. Otherwise it is a Write frame that carries the fetched bytes.

Every frame starts with a 14-byte header. Bytes 0-5 hold a fixed destination address. Bytes 6-11 hold the six-byte transfer header in place of the source address. Bytes 12-13 hold a fixed protocol value. Payload bytes follow from byte 14. The MAC appends the CRC. Jobs that arrive while a frame is in progress wait in one pending slot per job kind.

Top module: `vc_tx_framer`

## Requirements
- R1: While reset is asserted and right after it is released, `mac_req`, `tx_valid`, `tx_last` and every `ch_ready` bit are low.
- R2: A read job drives `ch_ready` only for the requested channel, with at most one bit high at a time. No other channel loses a byte.
- R3: The fetch accepts bytes from the selected channel until one of three things happens: it accepts a byte marked end-of-frame, the channel has no byte offered, or MAX_BYTES bytes have been taken. The number accepted is the size field, big-endian in bytes 10-11.
- R4: A fetch of zero bytes yields a 14-byte Null frame. It has type code 0x00 in byte 8, zero flags and size 0, and no payload.
- R5: A non-empty fetch yields a Write frame: type 0x02, size = count, and the fetched bytes from byte 14 in arrival order. Byte 9 carries the channel in bits 7:6, SOF in bit 0, EOF in bit 1 and EOFE in bit 2. SOF is set when the channel's previous accepted byte was an end-of-frame byte, or when no byte has been accepted yet. EOF is set when an end-of-frame byte was accepted. EOFE is set when that byte was also marked as an error.
- R6: Bytes 0-5 are DST_ADDR, most significant byte first. Bytes 6-7 hold the serial number, high byte first. Bytes 12-13 hold PROTO, high byte first.
- R7: `mac_req` rises only after the fetch completes, or directly for an acknowledge job, and stays high until `mac_gnt`. No byte is sent before the grant. Bytes follow on consecutive cycles starting the cycle after the grant, and `tx_last` marks the final byte.
- R8: An acknowledge job yields a 14-byte frame with type 0x04. It echoes the job's serial number, its channel in bits 7:6 of byte 9 with flags zero, and its size in bytes 10-11.
- R9: Jobs arriving during a frame are held and served after it ends. When both kinds are pending, the acknowledge goes first.
- R10: A job that arrives while a job of the same kind is already pending is dropped and never produces a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | One-cycle read job strobe |
| rd_sn | input | 16 | Serial number of the read job |
| rd_vc | input | $clog2(NCH) | Channel to read |
| ack_req | input | 1 | One-cycle acknowledge job strobe |
| ack_sn | input | 16 | Serial number to echo |
| ack_vc | input | $clog2(NCH) | Channel to echo |
| ack_size | input | 16 | Size to echo |
| ch_valid | input | NCH | Byte offered on each channel |
| ch_data | input | 8*NCH | Byte of each channel, channel i at bits 8i+7:8i |
| ch_eof | input | NCH | Offered byte ends a channel frame |
| ch_err | input | NCH | Offered end-of-frame byte carries an error |
| ch_ready | output | NCH | Offered byte is taken this cycle |
| mac_req | output | 1 | Request for the MAC transmit line |
| mac_gnt | input | 1 | Grant from the MAC, sampled while requesting |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
The only fixed latency is at the MAC edge. After the cycle in which `mac_gnt` is sampled high, byte 0 appears in the next cycle and every later byte one cycle after the one before. The bench therefore raises the grant at a falling edge and compares one byte per falling edge from the next one on, checking `tx_last` on the final byte and a quiet line after it. The time from a job to `mac_req` depends on how many bytes the channel offers, so the bench waits for `mac_req` with a bound instead of counting cycles. Before each job it predicts the fetch count and flags from its own copy of the channel queues and the per-channel frame-in-progress state. After each frame it compares every channel's read pointer to confirm that only the selected channel was drained, and by exactly the predicted count.

// File: rtl/vctx_pkg.sv
package vctx_pkg;
  localparam int HDR_BYTES = 14;
  localparam int FLG_SOF   = 0;
  localparam int FLG_EOF   = 1;
  localparam int FLG_EOFE  = 2;

  typedef enum logic [7:0] {
    FT_NULL  = 8'h00,
    FT_WRITE = 8'h02,
    FT_ACK   = 8'h04
  } ftype_e;
endpackage

// File: rtl/vctx_fetch.sv
module vctx_fetch #(
  parameter  int NCH       = 4,
  parameter  int MAX_BYTES = 512,
  localparam int VW        = $clog2(NCH),
  localparam int AW        = $clog2(MAX_BYTES),
  localparam int CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [VW-1:0]    go_vc,
  input  logic [NCH-1:0]   ch_valid,
  input  logic [NCH*8-1:0] ch_data,
  input  logic [NCH-1:0]   ch_eof,
  input  logic [NCH-1:0]   ch_err,
  output logic [NCH-1:0]   ch_ready,
  output logic             done,
  output logic [CW-1:0]    count,
  output logic             sof,
  output logic             eof,
  output logic             eofe,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data
);
  logic          active_q, active_d;
  logic [VW-1:0] vc_q, vc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          sof_q, sof_d, eof_q, eof_d, eofe_q, eofe_d;
  logic [NCH-1:0] mid_q;
  logic [7:0]    buf_mem [MAX_BYTES];

  logic       sel_valid, sel_eof, sel_err, take, stop;
  logic [7:0] sel_data;

  // channel multiplexer
  always_comb begin
    sel_valid = ch_valid[vc_q];
    sel_eof   = ch_eof[vc_q];
    sel_err   = ch_err[vc_q];
    sel_data  = ch_data[int'(vc_q)*8 +: 8];
    take      = active_q & sel_valid;
    stop      = active_q & (~sel_valid | sel_eof | (cnt_q == CW'(MAX_BYTES - 1)));
  end

  always_comb begin
    active_d = active_q;
    vc_d     = vc_q;
    cnt_d    = cnt_q;
    sof_d    = sof_q;
    eof_d    = eof_q;
    eofe_d   = eofe_q;
    done_d   = stop;
    if (go) begin
      active_d = 1'b1;
      vc_d     = go_vc;
      cnt_d    = '0;
      sof_d    = ~mid_q[go_vc];
      eof_d    = 1'b0;
      eofe_d   = 1'b0;
    end else begin
      if (stop) active_d = 1'b0;
      if (take) begin
        cnt_d = cnt_q + CW'(1);
        if (sel_eof) begin
          eof_d  = 1'b1;
          eofe_d = sel_err;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      vc_q     <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      sof_q    <= 1'b0;
      eof_q    <= 1'b0;
      eofe_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      vc_q     <= vc_d;
      cnt_q    <= cnt_d;
      done_q   <= done_d;
      sof_q    <= sof_d;
      eof_q    <= eof_d;
      eofe_q   <= eofe_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) buf_mem[cnt_q[AW-1:0]] <= sel_data;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_ready[g] = active_q && (vc_q == VW'(g)) && ch_valid[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mid_q[g] <= 1'b0;
      else if (take && vc_q == VW'(g))  mid_q[g] <= ~sel_eof;
    end
  end

  assign done    = done_q;
  assign count   = cnt_q;
  assign sof     = sof_q;
  assign eof     = eof_q;
  assign eofe    = eofe_q;
  assign rd_data = buf_mem[rd_addr];

  p_ready_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_ready));
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_BYTES));
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/vctx_seq.sv
module vctx_seq
  import vctx_pkg::*;
#(
  parameter  int          NCH       = 4,
  parameter  int          MAX_BYTES = 512,
  parameter  logic [47:0] DST_ADDR  = 48'h02_00_00_00_00_01,
  parameter  logic [15:0] PROTO     = 16'h88B5,
  localparam int          VW        = $clog2(NCH),
  localparam int          AW        = $clog2(MAX_BYTES),
  localparam int          CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [15:0]   rd_sn,
  input  logic [VW-1:0] rd_vc,
  input  logic          ack_req,
  input  logic [15:0]   ack_sn,
  input  logic [VW-1:0] ack_vc,
  input  logic [15:0]   ack_size,
  output logic          go,
  output logic [VW-1:0] go_vc,
  input  logic          done,
  input  logic [CW-1:0] count,
  input  logic          sof,
  input  logic          eof,
  input  logic          eofe,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          mac_req,
  input  logic          mac_gnt,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_REQ, S_SEND} state_e;

  state_e        st_q, st_d;
  logic          rp_q, rp_d, ap_q, ap_d;
  logic [15:0]   rsn_q, rsn_d, asn_q, asn_d, asz_q, asz_d;
  logic [VW-1:0] rvc_q, rvc_d, avc_q, avc_d;
  ftype_e        ft_q, ft_d;
  logic [15:0]   fsn_q, fsn_d, fsz_q, fsz_d, last_q, last_d, idx_q, idx_d;
  logic [VW-1:0] fvc_q, fvc_d;
  logic [2:0]    ffl_q, ffl_d;
  logic          take_ack, take_rd;
  logic [7:0]    hdr [16];

  assign take_ack = (st_q == S_IDLE) && ap_q;
  assign take_rd  = (st_q == S_IDLE) && rp_q && !ap_q;

  // pending slots, one per job kind
  always_comb begin
    rp_d  = take_rd  ? rd_req  : (rp_q | rd_req);
    ap_d  = take_ack ? ack_req : (ap_q | ack_req);
    rsn_d = rsn_q;  rvc_d = rvc_q;
    asn_d = asn_q;  avc_d = avc_q;  asz_d = asz_q;
    if (rd_req && (!rp_q || take_rd)) begin
      rsn_d = rd_sn;  rvc_d = rd_vc;
    end
    if (ack_req && (!ap_q || take_ack)) begin
      asn_d = ack_sn; avc_d = ack_vc; asz_d = ack_size;
    end
  end

  always_comb begin
    st_d = st_q;  ft_d = ft_q;  fsn_d = fsn_q;  fvc_d = fvc_q;
    ffl_d = ffl_q;  fsz_d = fsz_q;  last_d = last_q;  idx_d = idx_q;
    go = 1'b0;  mac_req = 1'b0;  tx_valid = 1'b0;  tx_last = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (take_ack) begin
          ft_d = FT_ACK;  fsn_d = asn_q;  fvc_d = avc_q;  ffl_d = '0;
          fsz_d = asz_q;  last_d = 16'(HDR_BYTES - 1);  st_d = S_REQ;
        end else if (take_rd) begin
          fsn_d = rsn_q;  fvc_d = rvc_q;  go = 1'b1;  st_d = S_FETCH;
        end
      end
      S_FETCH: begin
        if (done) begin
          fsz_d = 16'(count);
          if (count == '0) begin
            ft_d = FT_NULL;  ffl_d = '0;  last_d = 16'(HDR_BYTES - 1);
          end else begin
            ft_d = FT_WRITE;
            ffl_d[FLG_SOF] = sof;  ffl_d[FLG_EOF] = eof;  ffl_d[FLG_EOFE] = eofe;
            last_d = 16'(HDR_BYTES - 1) + 16'(count);
          end
          st_d = S_REQ;
        end
      end
      S_REQ: begin
        mac_req = 1'b1;
        if (mac_gnt) begin
          idx_d = '0;  st_d = S_SEND;
        end
      end
      S_SEND: begin
        tx_valid = 1'b1;
        tx_last  = (idx_q == last_q);
        idx_d    = idx_q + 16'd1;
        if (tx_last) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // header byte table, entries 14 and 15 unused
  always_comb begin
    for (int i = 0; i < 6; i++) hdr[i] = DST_ADDR[8*(5-i) +: 8];
    hdr[6]  = fsn_q[15:8];
    hdr[7]  = fsn_q[7:0];
    hdr[8]  = ft_q;
    hdr[9]  = (8'(fvc_q) << 6) | {5'b0, ffl_q};
    hdr[10] = fsz_q[15:8];
    hdr[11] = fsz_q[7:0];
    hdr[12] = PROTO[15:8];
    hdr[13] = PROTO[7:0];
    hdr[14] = 8'h00;
    hdr[15] = 8'h00;
  end

  assign go_vc   = rvc_q;
  assign rd_addr = AW'(idx_q - 16'(HDR_BYTES));
  assign tx_data = (idx_q < 16'(HDR_BYTES)) ? hdr[idx_q[3:0]] : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  rp_q <= 1'b0;  ap_q <= 1'b0;
      rsn_q <= '0;  rvc_q <= '0;  asn_q <= '0;  avc_q <= '0;  asz_q <= '0;
      ft_q <= FT_NULL;  fsn_q <= '0;  fvc_q <= '0;  ffl_q <= '0;
      fsz_q <= '0;  last_q <= '0;  idx_q <= '0;
    end else begin
      st_q <= st_d;  rp_q <= rp_d;  ap_q <= ap_d;
      rsn_q <= rsn_d;  rvc_q <= rvc_d;  asn_q <= asn_d;  avc_q <= avc_d;  asz_q <= asz_d;
      ft_q <= ft_d;  fsn_q <= fsn_d;  fvc_q <= fvc_d;  ffl_q <= ffl_d;
      fsz_q <= fsz_d;  last_q <= last_d;  idx_q <= idx_d;
    end
  end

  p_first_after_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(mac_gnt));
  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_req && !mac_gnt) |=> mac_req);
  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  p_ack_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_q && rp_q && st_q == S_IDLE) |=> (st_q == S_REQ));
endmodule

// File: rtl/vc_tx_framer.sv
module vc_tx_framer #(
  parameter  int          NCH       = 4,
  parameter  int          MAX_BYTES = 512,
  parameter  logic [47:0] DST_ADDR  = 48'h02_00_00_00_00_01,
  parameter  logic [15:0] PROTO     = 16'h88B5,
  localparam int          VW        = $clog2(NCH),
  localparam int          AW        = $clog2(MAX_BYTES),
  localparam int          CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [15:0]      rd_sn,
  input  logic [VW-1:0]    rd_vc,
  input  logic             ack_req,
  input  logic [15:0]      ack_sn,
  input  logic [VW-1:0]    ack_vc,
  input  logic [15:0]      ack_size,
  input  logic [NCH-1:0]   ch_valid,
  input  logic [NCH*8-1:0] ch_data,
  input  logic [NCH-1:0]   ch_eof,
  input  logic [NCH-1:0]   ch_err,
  output logic [NCH-1:0]   ch_ready,
  output logic             mac_req,
  input  logic             mac_gnt,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last
);
  logic          go, done, sof, eof, eofe;
  logic [VW-1:0] go_vc;
  logic [CW-1:0] count;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  vctx_seq #(.NCH(NCH), .MAX_BYTES(MAX_BYTES), .DST_ADDR(DST_ADDR), .PROTO(PROTO)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_sn(rd_sn), .rd_vc(rd_vc),
    .ack_req(ack_req), .ack_sn(ack_sn), .ack_vc(ack_vc), .ack_size(ack_size),
    .go(go), .go_vc(go_vc), .done(done), .count(count),
    .sof(sof), .eof(eof), .eofe(eofe),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .mac_req(mac_req), .mac_gnt(mac_gnt),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
  );

  vctx_fetch #(.NCH(NCH), .MAX_BYTES(MAX_BYTES)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(go), .go_vc(go_vc),
    .ch_valid(ch_valid), .ch_data(ch_data), .ch_eof(ch_eof), .ch_err(ch_err),
    .ch_ready(ch_ready), .done(done), .count(count),
    .sof(sof), .eof(eof), .eofe(eofe),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/vc_tx_framer_tb.sv
module vc_tx_framer_tb;
  localparam int          NCH  = 4;
  localparam int          MAXB = 512;
  localparam logic [47:0] DST  = 48'h02_00_00_00_00_01;
  localparam logic [15:0] PRO  = 16'h88B5;
  localparam int          QD   = 1024;

  // row: [31:30] vc, [29:20] bytes added, [19:10] eof position (1023 none), [9] err, [8:6] grant delay
  localparam logic [31:0] VEC [8] = '{
    {2'd0, 10'd0,   10'd1023, 1'b0, 3'd0, 6'd0},
    {2'd1, 10'd5,   10'd4,    1'b0, 3'd2, 6'd0},
    {2'd2, 10'd10,  10'd3,    1'b1, 3'd1, 6'd0},
    {2'd2, 10'd0,   10'd1023, 1'b0, 3'd4, 6'd0},
    {2'd2, 10'd3,   10'd2,    1'b0, 3'd0, 6'd0},
    {2'd3, 10'd600, 10'd1023, 1'b0, 3'd3, 6'd0},
    {2'd3, 10'd0,   10'd1023, 1'b0, 3'd1, 6'd0},
    {2'd0, 10'd1,   10'd0,    1'b0, 3'd5, 6'd0}
  };

  logic clk, rst_n;
  logic rd_req, ack_req, mac_gnt;
  logic [15:0] rd_sn, ack_sn, ack_size;
  logic [1:0]  rd_vc, ack_vc;
  logic [NCH-1:0] ch_valid, ch_eof, ch_err, ch_ready;
  logic [NCH*8-1:0] ch_data;
  logic mac_req, tx_valid, tx_last;
  logic [7:0] tx_data;

  logic [7:0] src_data [NCH][QD];
  logic       src_eof  [NCH][QD];
  logic       src_err  [NCH][QD];
  int         src_len  [NCH];
  int         src_ptr  [NCH];
  logic       mid      [NCH];
  logic [7:0] exp_b [QD + 16];
  int         exp_len;
  int         n_total, n_bad;

  vc_tx_framer #(.NCH(NCH), .MAX_BYTES(MAXB), .DST_ADDR(DST), .PROTO(PRO)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_sn(rd_sn), .rd_vc(rd_vc),
    .ack_req(ack_req), .ack_sn(ack_sn), .ack_vc(ack_vc), .ack_size(ack_size),
    .ch_valid(ch_valid), .ch_data(ch_data), .ch_eof(ch_eof), .ch_err(ch_err),
    .ch_ready(ch_ready), .mac_req(mac_req), .mac_gnt(mac_gnt),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ch_valid[i]        = src_ptr[i] < src_len[i];
      ch_data[i*8 +: 8]  = src_data[i][src_ptr[i]];
      ch_eof[i]          = src_eof[i][src_ptr[i]];
      ch_err[i]          = src_err[i][src_ptr[i]];
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < NCH; i++)
      if (ch_ready[i]) src_ptr[i] <= src_ptr[i] + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic load(input int vc, input int n, input int eofpos, input bit err, input int seed);
    for (int j = 0; j < n; j++) begin
      src_data[vc][src_len[vc]] = 8'(seed * 31 + j * 7 + 1);
      src_eof[vc][src_len[vc]]  = (j == eofpos);
      src_err[vc][src_len[vc]]  = err && (j == eofpos);
      src_len[vc]++;
    end
  endtask

  task automatic build_hdr(input logic [7:0] ft, input logic [15:0] sn, input int vc,
                           input logic [2:0] fl, input logic [15:0] sz);
    for (int i = 0; i < 6; i++) exp_b[i] = DST[8*(5-i) +: 8];
    exp_b[6]  = sn[15:8];  exp_b[7]  = sn[7:0];
    exp_b[8]  = ft;
    exp_b[9]  = (8'(vc) << 6) | {5'b0, fl};
    exp_b[10] = sz[15:8];  exp_b[11] = sz[7:0];
    exp_b[12] = PRO[15:8]; exp_b[13] = PRO[7:0];
    exp_len   = 14;
  endtask

  // predicts the frame for a read of channel vc from the bench's own queue copy
  task automatic model_read(input int vc, input logic [15:0] sn, output int cnt);
    int p; logic [2:0] fl;
    p = src_ptr[vc];  cnt = 0;  fl = '0;
    fl[0] = ~mid[vc];
    while (p < src_len[vc] && cnt < MAXB) begin
      exp_b[14 + cnt] = src_data[vc][p];
      cnt++;
      mid[vc] = ~src_eof[vc][p];
      if (src_eof[vc][p]) begin
        fl[1] = 1'b1;  fl[2] = src_err[vc][p];
        p++;
        break;
      end
      p++;
    end
    if (cnt == 0) build_hdr(8'h00, sn, vc, 3'b000, 16'd0);
    else begin
      build_hdr(8'h02, sn, vc, fl, 16'(cnt));
      exp_len = 14 + cnt;
    end
  endtask

  task automatic pulse_rd(input int vc, input logic [15:0] sn);
    rd_req = 1'b1;  rd_vc = 2'(vc);  rd_sn = sn;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic pulse_ack(input int vc, input logic [15:0] sn, input logic [15:0] sz);
    ack_req = 1'b1;  ack_vc = 2'(vc);  ack_sn = sn;  ack_size = sz;
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  // waits for the request, grants after dly cycles and compares the frame byte by byte
  task automatic recv(input int dly, input string tag);
    int w; int bad_at; logic [7:0] act, expv; bit early;
    w = 0;  bad_at = -1;  early = 1'b0;  act = '0;  expv = '0;
    while (!mac_req && w < 3000) begin
      if (tx_valid) early = 1'b1;
      @(negedge clk);  w++;
    end
    chk(mac_req, {tag, " R7 request"}, longint'(mac_req), 1);
    repeat (dly) begin
      @(negedge clk);
      if (tx_valid || !mac_req) early = 1'b1;
    end
    chk(!early, {tag, " R7 nothing before grant"}, longint'(early), 0);
    mac_gnt = 1'b1;
    @(negedge clk);
    mac_gnt = 1'b0;
    for (int k = 0; k < exp_len; k++) begin
      if (bad_at < 0 && (!tx_valid || tx_data !== exp_b[k] || tx_last !== (k == exp_len - 1))) begin
        bad_at = k;  act = tx_data;  expv = exp_b[k];
      end
      @(negedge clk);
    end
    if (bad_at < 0 && tx_valid) begin
      bad_at = exp_len;  act = 8'hFF;  expv = 8'h00;
    end
    chk(bad_at < 0, $sformatf("%s frame byte %0d", tag, bad_at), longint'(act), longint'(expv));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7 watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    int snap [NCH];
    bit same;
    n_total = 0;  n_bad = 0;
    rd_req = 0;  ack_req = 0;  mac_gnt = 0;
    rd_sn = '0;  rd_vc = '0;  ack_sn = '0;  ack_vc = '0;  ack_size = '0;
    for (int i = 0; i < NCH; i++) begin
      src_len[i] = 0;  src_ptr[i] = 0;  mid[i] = 1'b0;
      for (int j = 0; j < QD; j++) begin
        src_data[i][j] = '0;  src_eof[i][j] = 0;  src_err[i][j] = 0;
      end
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mac_req && !tx_valid && !tx_last && ch_ready == '0, "R1 outputs in reset",
        longint'({mac_req, tx_valid, tx_last, ch_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mac_req && !tx_valid && !tx_last && ch_ready == '0, "R1 outputs after reset",
        longint'({mac_req, tx_valid, tx_last, ch_ready}), 0);

    // table of read jobs: R2 R3 R4 R5 R6 R7
    for (int r = 0; r < 8; r++) begin
      logic [31:0] v;
      int vc;
      v  = VEC[r];
      vc = int'(v[31:30]);
      load(vc, int'(v[29:20]), int'(v[19:10]), v[9], r);
      for (int i = 0; i < NCH; i++) snap[i] = src_ptr[i];
      model_read(vc, 16'h1000 + 16'(r * 16'h0111), cnt);
      pulse_rd(vc, 16'h1000 + 16'(r * 16'h0111));
      recv(int'(v[8:6]), $sformatf("R3 R4 R5 R6 row %0d", r));
      same = 1'b1;
      for (int i = 0; i < NCH; i++)
        if (src_ptr[i] != snap[i] + ((i == vc) ? cnt : 0)) same = 1'b0;
      chk(same, $sformatf("R2 channel pointers row %0d", r), longint'(src_ptr[vc]),
          longint'(snap[vc] + cnt));
    end

    // lone acknowledge job: R8
    build_hdr(8'h04, 16'hBEEF, 2, 3'b000, 16'h1234);
    pulse_ack(2, 16'hBEEF, 16'h1234);
    recv(1, "R8 ack frame");

    // jobs arriving during a read: R9 and R10
    load(1, 4, 3, 1'b0, 40);
    load(3, 2, 1023, 1'b0, 41);
    for (int i = 0; i < NCH; i++) snap[i] = src_ptr[i];
    model_read(1, 16'h0A0A, cnt);
    pulse_rd(1, 16'h0A0A);
    while (!mac_req) @(negedge clk);
    pulse_ack(3, 16'h5A5A, 16'h0077);
    pulse_rd(0, 16'h0B0B);
    pulse_rd(3, 16'h0C0C);
    recv(2, "R9 read in progress");
    build_hdr(8'h04, 16'h5A5A, 3, 3'b000, 16'h0077);
    recv(0, "R9 ack served before pending read");
    model_read(0, 16'h0B0B, cnt);
    recv(1, "R9 pending read served last");
    same = 1'b1;
    repeat (40) begin
      if (mac_req || tx_valid || ch_ready != '0) same = 1'b0;
      @(negedge clk);
    end
    chk(same && src_ptr[3] == snap[3], "R10 dropped read leaves line and channel idle",
        longint'(src_ptr[3]), longint'(snap[3]));

    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule